// File: doc/BRIEF.md
# Microcoded Control Sequencer

This block produces the control strobes of a multi-cycle processor datapath from a small microprogram instead of a hand-built state machine. A 4-bit micro-address register selects one 17-bit microinstruction from a built-in control store. That word is split into narrow encoded fields (ALU function, operand A source, operand B source, register-file destination, memory action, instruction-register load, PC update and sequencing), and each field is decoded into individual strobes for the datapath.

The 2-bit sequencing field of each word picks the next micro-address from three sources. It can return to the fetch routine at address 0, step to the current address plus one, or jump through a dispatch table that maps the 6-bit opcode to the first word of that instruction's routine. The routines cover five instruction classes: load, store, register-register ALU, branch-on-equal and OR-immediate. Both the control store and the dispatch table are constants inside the block. An opcode with no entry in the dispatch table sends the sequencer back to fetch and flags it. The datapath itself is outside this block. Only the ALU zero flag comes back in, and it gates the conditional PC load.

Top module: `ucode_sequencer`

## Requirements
- R1: With `rst` high at a rising edge, the next cycle shows `uaddr` = 0, `bad_opcode` = 0 and the fetch strobes of R6.
- R2: A word whose sequencing field is "step" (10) at addresses 0, 2, 3, 5, 7 and 10 makes `uaddr` one higher after the next rising edge.
- R3: A word whose sequencing field is "fetch" (00) at addresses 4, 6, 8, 9 and 11 makes `uaddr` return to 0 after the next rising edge.
- R4: At address 1 (sequencing field "dispatch", 01), the opcode sampled at the rising edge selects the next address: 0x23 goes to 2, 0x2B goes to 5, 0x00 goes to 7, 0x04 goes to 9 and 0x0D goes to 10.
- R5: Any other opcode at a dispatch sends `uaddr` to 0 and holds `bad_opcode` high for exactly that one cycle at address 0.
- R6: At address 0 the strobes are: ALU add, operand A = PC, operand B = constant four, memory read addressed by PC, instruction-register load, and unconditional PC load from the ALU result. `pc_load` is high.
- R7: At address 1 the strobes are: ALU add, operand A = PC, operand B = sign-extended immediate shifted left by two. No write strobe is active.
- R8: The load routine (2, 3, 4) drives three words in turn. The first adds register rs to the sign-extended immediate. The second reads memory addressed by the ALU register. The third writes memory data into register rt.
- R9: The store routine (5, 6) first adds rs to the sign-extended immediate. It then writes memory addressed by the ALU register.
- R10: The register-register routine (7, 8) first applies the function-code ALU operation to rs and rt. It then writes the ALU register into rd.
- R11: The branch word (9) subtracts rt from rs and raises `pc_we_cond` with `pc_from_reg` set. `pc_load` then follows `alu_zero` in the same cycle.
- R12: The OR-immediate routine (10, 11) first ORs rs with the zero-extended immediate. It then writes the ALU register into rt.
- R13: The encodings are as follows. `alu_fn`: 00 add, 01 subtract, 10 function code, 11 OR. `opa_sel`: 0 PC, 1 rs. `opb_sel`: 000 rt, 001 four, 010 sign-extended, 011 sign-extended shifted, 100 zero-extended. `rf_dst_rd`: 1 selects rd, 0 selects rt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Instruction opcode, used at a dispatch |
| alu_zero | input | 1 | ALU zero flag for the conditional PC load |
| uaddr | output | 4 | Current micro-address |
| bad_opcode | output | 1 | High at address 0 right after a dispatch on an unmapped opcode |
| alu_fn | output | 2 | ALU operation select |
| opa_sel | output | 1 | ALU operand A source |
| opb_sel | output | 3 | ALU operand B source |
| rf_we | output | 1 | Register-file write enable |
| rf_wsrc_mem | output | 1 | Register write data from memory (else ALU register) |
| rf_dst_rd | output | 1 | Destination register rd (else rt) |
| mem_re | output | 1 | Memory read |
| mem_we | output | 1 | Memory write |
| mem_addr_alu | output | 1 | Memory address from ALU register (else PC) |
| ir_we | output | 1 | Instruction register load |
| pc_we | output | 1 | Unconditional PC load |
| pc_we_cond | output | 1 | PC load if ALU zero |
| pc_from_reg | output | 1 | PC source is ALU register (else live ALU result) |
| pc_load | output | 1 | Effective PC load enable |

## Verification
The micro-address and every field strobe come from registers. The values set up by one rising edge are therefore checked from the falling edge that follows it until the next rising edge. The opcode and reset driven before an edge show their effect at the next falling edge, and `bad_opcode` appears together with the return to address 0. `pc_load` is the only output that depends on an input in the same cycle. The bench changes `alu_zero` at the falling edge and samples `pc_load` a time unit later, before the next edge. The bench moves a model micro-address forward once per edge. It compares `uaddr`, the strobes, `bad_opcode` and `pc_load` against that model address, so every result is checked in the exact cycle it is due.

// File: rtl/useq_pkg.sv
package useq_pkg;

  localparam int UA_W   = 4;
  localparam int OP_W   = 6;
  localparam int WORD_W = 17;

  typedef enum logic [1:0] {
    SQ_FETCH = 2'b00,
    SQ_DISP  = 2'b01,
    SQ_NEXT  = 2'b10,
    SQ_RSVD  = 2'b11
  } seq_e;

  localparam logic [1:0] ALU_ADD  = 2'b00;
  localparam logic [1:0] ALU_SUB  = 2'b01;
  localparam logic [1:0] ALU_FUNC = 2'b10;
  localparam logic [1:0] ALU_OR   = 2'b11;

  localparam logic [2:0] OPB_RT   = 3'b000;
  localparam logic [2:0] OPB_FOUR = 3'b001;
  localparam logic [2:0] OPB_SX   = 3'b010;
  localparam logic [2:0] OPB_SXSH = 3'b011;
  localparam logic [2:0] OPB_ZX   = 3'b100;

  localparam logic [1:0] DST_NONE  = 2'b00;
  localparam logic [1:0] DST_RD_AL = 2'b01;
  localparam logic [1:0] DST_RT_AL = 2'b10;
  localparam logic [1:0] DST_RT_MM = 2'b11;

  localparam logic [2:0] MEM_NONE  = 3'b000;
  localparam logic [2:0] MEM_RD_PC = 3'b001;
  localparam logic [2:0] MEM_RD_AL = 3'b010;
  localparam logic [2:0] MEM_WR_AL = 3'b011;

  localparam logic [2:0] PCW_NONE = 3'b000;
  localparam logic [2:0] PCW_ALU  = 3'b001;
  localparam logic [2:0] PCW_COND = 3'b010;

  localparam logic [OP_W-1:0] OPC_REG   = 6'h00;
  localparam logic [OP_W-1:0] OPC_BREQ  = 6'h04;
  localparam logic [OP_W-1:0] OPC_ORIM  = 6'h0D;
  localparam logic [OP_W-1:0] OPC_LOAD  = 6'h23;
  localparam logic [OP_W-1:0] OPC_STORE = 6'h2B;

  localparam logic [UA_W-1:0] UA_FETCH  = 4'd0;
  localparam logic [UA_W-1:0] UA_DECODE = 4'd1;
  localparam logic [UA_W-1:0] UA_LOAD   = 4'd2;
  localparam logic [UA_W-1:0] UA_STORE  = 4'd5;
  localparam logic [UA_W-1:0] UA_REG    = 4'd7;
  localparam logic [UA_W-1:0] UA_BREQ   = 4'd9;
  localparam logic [UA_W-1:0] UA_ORIM   = 4'd10;

  typedef struct packed {
    logic [1:0] alu;
    logic       opa;
    logic [2:0] opb;
    logic [1:0] dst;
    logic [2:0] mem;
    logic       irw;
    logic [2:0] pcw;
    seq_e       seq;
  } uword_t;

  function automatic uword_t ucode_word(input logic [UA_W-1:0] a);
    uword_t w;
    w.alu = ALU_ADD;
    w.opa = 1'b0;
    w.opb = OPB_RT;
    w.dst = DST_NONE;
    w.mem = MEM_NONE;
    w.irw = 1'b0;
    w.pcw = PCW_NONE;
    w.seq = SQ_FETCH;
    case (a)
      4'd0: begin
        w.opb = OPB_FOUR; w.mem = MEM_RD_PC; w.irw = 1'b1;
        w.pcw = PCW_ALU;  w.seq = SQ_NEXT;
      end
      4'd1: begin w.opb = OPB_SXSH; w.seq = SQ_DISP; end
      4'd2: begin w.opa = 1'b1; w.opb = OPB_SX; w.seq = SQ_NEXT; end
      4'd3: begin w.mem = MEM_RD_AL; w.seq = SQ_NEXT; end
      4'd4: begin w.dst = DST_RT_MM; end
      4'd5: begin w.opa = 1'b1; w.opb = OPB_SX; w.seq = SQ_NEXT; end
      4'd6: begin w.mem = MEM_WR_AL; end
      4'd7: begin w.alu = ALU_FUNC; w.opa = 1'b1; w.seq = SQ_NEXT; end
      4'd8: begin w.dst = DST_RD_AL; end
      4'd9: begin w.alu = ALU_SUB; w.opa = 1'b1; w.pcw = PCW_COND; end
      4'd10: begin
        w.alu = ALU_OR; w.opa = 1'b1; w.opb = OPB_ZX; w.seq = SQ_NEXT;
      end
      4'd11: begin w.dst = DST_RT_AL; end
      default: ;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/useq_store.sv
module useq_store
  import useq_pkg::*;
#(
  parameter int AW = UA_W,
  parameter int DW = WORD_W
) (
  input  logic          clk,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_word
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] rom [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      rom[i] = DW'(ucode_word(UA_W'(i)));
    end
  end

  // synchronous read, block-RAM style
  always_ff @(posedge clk) begin
    rd_word <= rom[rd_addr];
  end

endmodule

// File: rtl/useq_dispatch.sv
module useq_dispatch
  import useq_pkg::*;
#(
  parameter int OW = OP_W,
  parameter int AW = UA_W
) (
  input  logic [OW-1:0] opcode,
  output logic [AW-1:0] target,
  output logic          hit
);
  always_comb begin
    hit    = 1'b1;
    target = '0;
    case (opcode)
      OW'(OPC_LOAD):  target = AW'(UA_LOAD);
      OW'(OPC_STORE): target = AW'(UA_STORE);
      OW'(OPC_REG):   target = AW'(UA_REG);
      OW'(OPC_BREQ):  target = AW'(UA_BREQ);
      OW'(OPC_ORIM):  target = AW'(UA_ORIM);
      default:        hit    = 1'b0;
    endcase
  end

endmodule

// File: rtl/useq_next.sv
module useq_next
  import useq_pkg::*;
#(
  parameter int AW = UA_W
) (
  input  logic          rst,
  input  seq_e          seq,
  input  logic [AW-1:0] cur,
  input  logic [AW-1:0] disp_tgt,
  input  logic          disp_hit,
  output logic [AW-1:0] nxt,
  output logic          bad_nxt
);
  always_comb begin
    nxt     = '0;
    bad_nxt = 1'b0;
    if (!rst) begin
      case (seq)
        SQ_NEXT: nxt = cur + AW'(1);
        SQ_DISP: begin
          if (disp_hit) nxt = disp_tgt;
          else          bad_nxt = 1'b1;
        end
        default: nxt = '0;
      endcase
    end
  end

endmodule

// File: rtl/useq_decode.sv
module useq_decode
  import useq_pkg::*;
(
  input  uword_t     w,
  output logic [1:0] alu_fn,
  output logic       opa_sel,
  output logic [2:0] opb_sel,
  output logic       rf_we,
  output logic       rf_wsrc_mem,
  output logic       rf_dst_rd,
  output logic       mem_re,
  output logic       mem_we,
  output logic       mem_addr_alu,
  output logic       ir_we,
  output logic       pc_we,
  output logic       pc_we_cond,
  output logic       pc_from_reg
);
  always_comb begin
    alu_fn       = w.alu;
    opa_sel      = w.opa;
    opb_sel      = w.opb;
    rf_we        = (w.dst != DST_NONE);
    rf_wsrc_mem  = (w.dst == DST_RT_MM);
    rf_dst_rd    = (w.dst == DST_RD_AL);
    mem_re       = (w.mem == MEM_RD_PC) || (w.mem == MEM_RD_AL);
    mem_we       = (w.mem == MEM_WR_AL);
    mem_addr_alu = (w.mem == MEM_RD_AL) || (w.mem == MEM_WR_AL);
    ir_we        = w.irw;
    pc_we        = (w.pcw == PCW_ALU);
    pc_we_cond   = (w.pcw == PCW_COND);
    pc_from_reg  = (w.pcw == PCW_COND);
  end

endmodule

// File: rtl/ucode_sequencer.sv
module ucode_sequencer
  import useq_pkg::*;
#(
  parameter int OW = OP_W,
  parameter int AW = UA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [OW-1:0] opcode,
  input  logic          alu_zero,
  output logic [AW-1:0] uaddr,
  output logic          bad_opcode,
  output logic [1:0]    alu_fn,
  output logic          opa_sel,
  output logic [2:0]    opb_sel,
  output logic          rf_we,
  output logic          rf_wsrc_mem,
  output logic          rf_dst_rd,
  output logic          mem_re,
  output logic          mem_we,
  output logic          mem_addr_alu,
  output logic          ir_we,
  output logic          pc_we,
  output logic          pc_we_cond,
  output logic          pc_from_reg,
  output logic          pc_load
);
  logic [AW-1:0]     ua_q, ua_d, disp_tgt;
  logic              bad_q, bad_d, disp_hit;
  logic [WORD_W-1:0] word_raw;
  uword_t            uw;

  assign uw = uword_t'(word_raw);

  useq_dispatch #(.OW(OW), .AW(AW)) u_disp (
    .opcode (opcode),
    .target (disp_tgt),
    .hit    (disp_hit)
  );

  useq_next #(.AW(AW)) u_next (
    .rst      (rst),
    .seq      (uw.seq),
    .cur      (ua_q),
    .disp_tgt (disp_tgt),
    .disp_hit (disp_hit),
    .nxt      (ua_d),
    .bad_nxt  (bad_d)
  );

  // the store is read with the next address so its word lines up with ua_q
  useq_store #(.AW(AW), .DW(WORD_W)) u_store (
    .clk     (clk),
    .rd_addr (ua_d),
    .rd_word (word_raw)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ua_q  <= '0;
      bad_q <= 1'b0;
    end else begin
      ua_q  <= ua_d;
      bad_q <= bad_d;
    end
  end

  useq_decode u_dec (
    .w            (uw),
    .alu_fn       (alu_fn),
    .opa_sel      (opa_sel),
    .opb_sel      (opb_sel),
    .rf_we        (rf_we),
    .rf_wsrc_mem  (rf_wsrc_mem),
    .rf_dst_rd    (rf_dst_rd),
    .mem_re       (mem_re),
    .mem_we       (mem_we),
    .mem_addr_alu (mem_addr_alu),
    .ir_we        (ir_we),
    .pc_we        (pc_we),
    .pc_we_cond   (pc_we_cond),
    .pc_from_reg  (pc_from_reg)
  );

  assign uaddr      = ua_q;
  assign bad_opcode = bad_q;
  assign pc_load    = pc_we | (pc_we_cond & alu_zero);

  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
    (uw.seq == SQ_NEXT) |=> (uaddr == $past(uaddr) + 1'b1)); // R2
  AST_FETCH_RET: assert property (@(posedge clk) disable iff (rst)
    (uw.seq == SQ_FETCH) |=> (uaddr == '0)); // R3
  AST_MISS_FLAG: assert property (@(posedge clk) disable iff (rst)
    (uw.seq == SQ_DISP && !disp_hit) |=> (bad_opcode && uaddr == '0)); // R5
  AST_FLAG_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    bad_opcode |=> !bad_opcode); // R5
  AST_PC_GATE: assert property (@(posedge clk) disable iff (rst)
    (pc_load && !pc_we) |-> (alu_zero && pc_we_cond)); // R11

endmodule

// File: tb/ucode_sequencer_test.sv
module ucode_sequencer_test;
  localparam int CLK_PERIOD = 10;

  logic       clk, rst, alu_zero;
  logic [5:0] opcode;
  logic [3:0] uaddr;
  logic       bad_opcode;
  logic [1:0] alu_fn;
  logic       opa_sel;
  logic [2:0] opb_sel;
  logic rf_we, rf_wsrc_mem, rf_dst_rd, mem_re, mem_we, mem_addr_alu;
  logic ir_we, pc_we, pc_we_cond, pc_from_reg, pc_load;

  int checks = 0;
  int errors = 0;
  logic [3:0] exp_ua = 4'd0;
  logic       exp_bad = 1'b0;
  string      ua_tag = "R1";

  ucode_sequencer uut (
    .clk(clk), .rst(rst), .opcode(opcode), .alu_zero(alu_zero),
    .uaddr(uaddr), .bad_opcode(bad_opcode), .alu_fn(alu_fn),
    .opa_sel(opa_sel), .opb_sel(opb_sel), .rf_we(rf_we),
    .rf_wsrc_mem(rf_wsrc_mem), .rf_dst_rd(rf_dst_rd), .mem_re(mem_re),
    .mem_we(mem_we), .mem_addr_alu(mem_addr_alu), .ir_we(ir_we),
    .pc_we(pc_we), .pc_we_cond(pc_we_cond), .pc_from_reg(pc_from_reg),
    .pc_load(pc_load)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // {alu_fn, opa_sel, opb_sel, rf_we, rf_wsrc_mem, rf_dst_rd,
  //  mem_re, mem_we, mem_addr_alu, ir_we, pc_we, pc_we_cond, pc_from_reg}
  function automatic logic [15:0] want_fields(input logic [3:0] a);
    case (a)
      4'd0:  return {2'b00, 1'b0, 3'b001, 3'b000, 3'b100, 1'b1, 3'b100};
      4'd1:  return {2'b00, 1'b0, 3'b011, 3'b000, 3'b000, 1'b0, 3'b000};
      4'd2,
      4'd5:  return {2'b00, 1'b1, 3'b010, 3'b000, 3'b000, 1'b0, 3'b000};
      4'd3:  return {2'b00, 1'b0, 3'b000, 3'b000, 3'b101, 1'b0, 3'b000};
      4'd4:  return {2'b00, 1'b0, 3'b000, 3'b110, 3'b000, 1'b0, 3'b000};
      4'd6:  return {2'b00, 1'b0, 3'b000, 3'b000, 3'b011, 1'b0, 3'b000};
      4'd7:  return {2'b10, 1'b1, 3'b000, 3'b000, 3'b000, 1'b0, 3'b000};
      4'd8:  return {2'b00, 1'b0, 3'b000, 3'b101, 3'b000, 1'b0, 3'b000};
      4'd9:  return {2'b01, 1'b1, 3'b000, 3'b000, 3'b000, 1'b0, 3'b011};
      4'd10: return {2'b11, 1'b1, 3'b100, 3'b000, 3'b000, 1'b0, 3'b000};
      4'd11: return {2'b00, 1'b0, 3'b000, 3'b100, 3'b000, 1'b0, 3'b000};
      default: return 16'h0000;
    endcase
  endfunction

  function automatic string field_tag(input logic [3:0] a);
    case (a)
      4'd0: return "R6/R13";
      4'd1: return "R7/R13";
      4'd2, 4'd3, 4'd4: return "R8/R13";
      4'd5, 4'd6: return "R9/R13";
      4'd7, 4'd8: return "R10/R13";
      4'd9: return "R11/R13";
      default: return "R12/R13";
    endcase
  endfunction

  function automatic logic [4:0] start_of(input logic [5:0] op);
    // bit 4 = opcode is mapped
    case (op)
      6'h23: return {1'b1, 4'd2};
      6'h2B: return {1'b1, 4'd5};
      6'h00: return {1'b1, 4'd7};
      6'h04: return {1'b1, 4'd9};
      6'h0D: return {1'b1, 4'd10};
      default: return 5'd0;
    endcase
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic [5:0] op, input logic z, input logic r);
    logic [4:0] s;
    @(negedge clk);
    opcode   = op;
    alu_zero = z;
    rst      = r;
    #1;
    check(ua_tag, "uaddr", 32'(uaddr), 32'(exp_ua));
    check(field_tag(exp_ua), "fields",
          32'({alu_fn, opa_sel, opb_sel, rf_we, rf_wsrc_mem, rf_dst_rd,
               mem_re, mem_we, mem_addr_alu, ir_we, pc_we, pc_we_cond,
               pc_from_reg}), 32'(want_fields(exp_ua)));
    check("R5", "bad_opcode", 32'(bad_opcode), 32'(exp_bad));
    check((exp_ua == 4'd9) ? "R11" : "R6", "pc_load", 32'(pc_load),
          32'((exp_ua == 4'd0) || (exp_ua == 4'd9 && z)));
    exp_bad = 1'b0;
    if (r) begin
      exp_ua = 4'd0;
      ua_tag = "R1";
    end else begin
      case (exp_ua)
        4'd0, 4'd2, 4'd3, 4'd5, 4'd7, 4'd10: begin
          exp_ua = exp_ua + 4'd1;
          ua_tag = "R2";
        end
        4'd1: begin
          s = start_of(op);
          exp_ua  = s[3:0];
          exp_bad = !s[4];
          ua_tag  = s[4] ? "R4" : "R5";
        end
        default: begin
          exp_ua = 4'd0;
          ua_tag = "R3";
        end
      endcase
    end
  endtask

  task automatic run_instr(input logic [5:0] op, input logic z);
    step(op, z, 1'b0);
    while (exp_ua != 4'd0) step(op, z, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EC0_0D1E));
    rst      = 1'b1;
    opcode   = 6'h00;
    alu_zero = 1'b0;
    // R1: reset state
    step(6'h00, 1'b0, 1'b1);
    step(6'h00, 1'b0, 1'b0);
    while (exp_ua != 4'd0) step(6'h00, 1'b0, 1'b0);
    // directed classes: R8 load, R9 store, R10 reg, R11 branch, R12 or-imm
    run_instr(6'h23, 1'b0);
    run_instr(6'h2B, 1'b1);
    run_instr(6'h00, 1'b0);
    run_instr(6'h04, 1'b1);
    run_instr(6'h04, 1'b0);
    run_instr(6'h0D, 1'b1);
    // R5: unmapped opcodes
    run_instr(6'h3F, 1'b0);
    run_instr(6'h05, 1'b1);
    // R1: reset in the middle of the load routine
    step(6'h23, 1'b0, 1'b0);
    step(6'h23, 1'b0, 1'b0);
    step(6'h23, 1'b0, 1'b0);
    step(6'h23, 1'b0, 1'b1);
    step(6'h23, 1'b0, 1'b0);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [5:0] op;
      int pick;
      pick = $urandom % 8;
      case (pick)
        0: op = 6'h23;
        1: op = 6'h2B;
        2: op = 6'h00;
        3: op = 6'h04;
        4: op = 6'h0D;
        default: op = 6'($urandom);
      endcase
      step(op, 1'($urandom), ($urandom % 101) == 0);
    end
    step(6'h00, 1'b0, 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule